// File: doc/BRIEF.md
# High-Impedance and Pre-Overvoltage Supervisor

This block sits between the input conditioning of a synchronous buck gate driver and its gate sequencer. Each clock cycle it decides one of three things. The sequencer may follow the PWM command. Both switches may have to stay off in a high-impedance (HiZ) state. Or the low-side switch may have to be latched on, so that it clamps the output when the switch node rises while the driver is parked.

The inputs are already digital. They are a supply-good flag from undervoltage lockout, the enable pin and a two-bit classification of the PWM pin voltage (low, mid-window or high). A comparator flag reports the switch node above its pre-overvoltage threshold. A mid-window PWM level must persist for a hold-off time before it counts as HiZ. HiZ is left only when PWM moves to logic low. The protection latch can only be set while in HiZ, and it is cleared when PWM moves out of the mid window.

Top module: `hiz_ovp_supervisor`

## Requirements
- R1: While `uvlo_ok_i` is low, in the same cycle, `hiz_o`=1, `force_ls_on_o`=0 and `run_enable_o`=0, whatever `en_i`, `pwm_lvl_i` and `phase_ov_i` are.
- R2: After reset, or after `uvlo_ok_i` rises, the block is in HiZ. The last PWM level is taken as mid-window at that point. It leaves HiZ one clock edge after a sampled PWM level of low (code 00) that differs from the level sampled before it, provided `en_i` is high.
- R3: A low `en_i` sampled at a clock edge puts the block in HiZ after that edge, whatever the PWM level, and keeps it there while `en_i` stays low.
- R4: PWM codes 01 and 11 both count as mid-window. With `en_i` high and the block running, `HOLDOFF` consecutive mid-window samples (default 8) enter HiZ after the HOLDOFF-th edge. `HOLDOFF`-1 samples do not enter HiZ.
- R5: The hold-off count restarts whenever PWM leaves the mid window, so broken runs of mid samples never add up.
- R6: Inside HiZ, a move of PWM to high (code 10) does not leave HiZ.
- R7: The protection is armed only in HiZ. `phase_ov_i` has no effect while the block is running.
- R8: `phase_ov_i` sampled high while armed sets `force_ls_on_o` after that edge. The latch then holds with the flag low. While the latch is set, `hiz_o` and `run_enable_o` are low.
- R9: A PWM move from mid-window to a non-mid level clears the latch at that edge. Clearing wins over a simultaneous trip.
- R10: A low `uvlo_ok_i` clears the protection latch. The latch stays clear after the supply returns.
- R11: `run_enable_o` is low whenever `hiz_o` or `force_ls_on_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uvlo_ok_i | input | 1 | Supply above lockout threshold |
| en_i | input | 1 | Driver enable |
| pwm_lvl_i | input | 2 | PWM class: 00 low, 01/11 mid-window, 10 high |
| phase_ov_i | input | 1 | Switch node above pre-overvoltage threshold |
| run_enable_o | output | 1 | Sequencer may follow PWM |
| force_ls_on_o | output | 1 | Hold low-side switch on |
| hiz_o | output | 1 | Both switches held off |

## Verification
Some properties hold on every cycle and are checked that way. The lockout state forces the all-off outputs. Run permission never coincides with HiZ or the clamp. Disabling always lands in HiZ. HiZ is only left after a low PWM sample. The clamp only rises from an armed HiZ state. The hold-off count stays in range. Other behaviour can only be shown by the bench's stimulus sequences: the exact edge on which hold-off expires, the restart of the count on a broken mid run, the missing exit on a move to high, and the clearing of the latch by a PWM move and by a supply drop.

// File: rtl/hiz_sup_pkg.sv
package hiz_sup_pkg;
  typedef enum logic [1:0] {
    PWM_LOW  = 2'b00,
    PWM_MID  = 2'b01,
    PWM_HIGH = 2'b10,
    PWM_RSV  = 2'b11
  } pwm_lvl_e;

  function automatic logic lvl_is_mid(logic [1:0] lvl);
    return (lvl == PWM_MID) || (lvl == PWM_RSV);
  endfunction
endpackage

// File: rtl/hiz_pwm_edge.sv
module hiz_pwm_edge
  import hiz_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [1:0] lvl_i,
  output logic       to_low_o,
  output logic       left_mid_o
);
  logic [1:0] prev_q;

  // a parked input sits mid-window, so start from there
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    prev_q <= PWM_MID;
    else if (clr_i) prev_q <= PWM_MID;
    else            prev_q <= lvl_i;
  end

  assign to_low_o   = (lvl_i == PWM_LOW) && (prev_q != PWM_LOW);
  assign left_mid_o = lvl_is_mid(prev_q) && !lvl_is_mid(lvl_i);
endmodule

// File: rtl/hiz_holdoff_timer.sv
module hiz_holdoff_timer #(
  parameter int unsigned HOLDOFF = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(HOLDOFF + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLDOFF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LIM)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LIM);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/hiz_ovp_latch.sv
module hiz_ovp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic trip_i,
  input  logic release_i,
  output logic latch_o
);
  logic latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                latch_q <= 1'b0;
    else if (clr_i)             latch_q <= 1'b0;
    else if (release_i)         latch_q <= 1'b0;
    else if (arm_i && trip_i)   latch_q <= 1'b1;
  end

  assign latch_o = latch_q;

  p_arm_only_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_q) |-> $past(arm_i));
  p_supply_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !latch_q);
endmodule

// File: rtl/hiz_ovp_supervisor.sv
module hiz_ovp_supervisor
  import hiz_sup_pkg::*;
#(
  parameter int unsigned HOLDOFF = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       uvlo_ok_i,
  input  logic       en_i,
  input  logic [1:0] pwm_lvl_i,
  input  logic       phase_ov_i,
  output logic       run_enable_o,
  output logic       force_ls_on_o,
  output logic       hiz_o
);
  logic hiz_q;
  logic to_low, left_mid, expire, ovp;
  logic supply_lost;
  logic count_run;

  assign supply_lost = !uvlo_ok_i;
  assign count_run   = uvlo_ok_i && en_i && !hiz_q && lvl_is_mid(pwm_lvl_i);

  hiz_pwm_edge u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (supply_lost),
    .lvl_i      (pwm_lvl_i),
    .to_low_o   (to_low),
    .left_mid_o (left_mid)
  );

  hiz_holdoff_timer #(.HOLDOFF(HOLDOFF)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (count_run),
    .expire_o (expire)
  );

  hiz_ovp_latch u_ovp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (supply_lost),
    .arm_i     (hiz_q),
    .trip_i    (phase_ov_i),
    .release_i (left_mid),
    .latch_o   (ovp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   hiz_q <= 1'b1;
    else if (supply_lost)          hiz_q <= 1'b1;
    else if (!en_i)                hiz_q <= 1'b1;
    else if (hiz_q && to_low)      hiz_q <= 1'b0;
    else if (expire)               hiz_q <= 1'b1;
  end

  // clamp outranks the all-off status
  assign force_ls_on_o = uvlo_ok_i && ovp;
  assign hiz_o         = supply_lost || (hiz_q && !ovp);
  assign run_enable_o  = uvlo_ok_i && !hiz_q && !ovp;

  p_lockout_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uvlo_ok_i |-> hiz_o && !force_ls_on_o && !run_enable_o);
  p_disable_hiz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uvlo_ok_i && !en_i) |=> hiz_q);
  p_exit_on_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hiz_q) |-> ($past(pwm_lvl_i) == PWM_LOW) && $past(en_i));
  p_run_exclusive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_enable_o |-> !hiz_o && !force_ls_on_o);
endmodule

// File: tb/hiz_ovp_supervisor_bench.sv
module hiz_ovp_supervisor_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo_ok = 1'b0, en = 1'b0, ov = 1'b0;
  logic [1:0] pwm = 2'b01;
  logic run_en, force_ls, hiz;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    logic run;
    logic frc;
    logic hz;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [1:0] LO = 2'b00, MD = 2'b01, HI = 2'b10, RS = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiz_ovp_supervisor u_hiz_ovp_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .uvlo_ok_i(uvlo_ok), .en_i(en),
    .pwm_lvl_i(pwm), .phase_ov_i(ov),
    .run_enable_o(run_en), .force_ls_on_o(force_ls), .hiz_o(hiz)
  );

  task automatic compare(logic r, logic f, logic h, string tag);
    n_checks++;
    if ({run_en, force_ls, hiz} !== {r, f, h}) begin
      n_errors++;
      $display("FAIL %s: run/force/hiz got %b%b%b expected %b%b%b",
               tag, run_en, force_ls, hiz, r, f, h);
    end
  endtask

  // driver: set inputs at negedge, expectation is for the following posedge
  task automatic step(logic u, logic e, logic [1:0] p, logic o,
                      logic r, logic f, logic h, string tag);
    exp_t x;
    @(negedge clk);
    uvlo_ok = u; en = e; pwm = p; ov = o;
    x.run = r; x.frc = f; x.hz = h; x.tag = tag;
    sb_q.push_back(x);
  endtask

  // monitor: sample a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        compare(x.run, x.frc, x.hz, x.tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_errors++;
    $display("FAIL watchdog: run/force/hiz got %b%b%b expected completion", run_en, force_ls, hiz);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    compare(1'b0, 1'b0, 1'b1, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: lockout ignores everything
    step(0, 1, LO, 1, 0, 0, 1, "R1 lockout pwm low ov high");
    step(0, 1, HI, 1, 0, 0, 1, "R1 lockout pwm high");
    step(0, 1, LO, 0, 0, 0, 1, "R1 lockout pwm low again");
    // R2: start in HiZ
    step(1, 1, MD, 0, 0, 0, 1, "R2 supply up parked mid");
    step(1, 1, HI, 0, 0, 0, 1, "R6 move to high stays hiz");
    step(1, 1, LO, 0, 1, 0, 0, "R2 exit on low transition");
    // R7: phase flag while running ignored
    step(1, 1, HI, 1, 1, 0, 0, "R7 ov while running high");
    step(1, 1, LO, 1, 1, 0, 0, "R7 ov while running low");
    step(1, 1, HI, 0, 1, 0, 0, "R11 running");
    // R5: broken mid runs
    for (int i = 0; i < 5; i++) step(1, 1, MD, 0, 1, 0, 0, "R5 first mid run");
    step(1, 1, HI, 0, 1, 0, 0, "R5 break run");
    for (int i = 0; i < 7; i++) step(1, 1, RS, 0, 1, 0, 0, "R5 second run code 11");
    step(1, 1, LO, 0, 1, 0, 0, "R4 short of holdoff");
    // R4: full hold-off
    for (int i = 0; i < 7; i++) step(1, 1, MD, 0, 1, 0, 0, "R4 counting");
    step(1, 1, MD, 0, 0, 0, 1, "R4 holdoff expired");
    step(1, 1, MD, 0, 0, 0, 1, "R4 stays hiz");
    // R8: trip and hold
    step(1, 1, MD, 1, 0, 1, 0, "R8 trip in hiz");
    step(1, 1, MD, 0, 0, 1, 0, "R8 latch holds");
    // R9: release on leaving mid, clear beats trip
    step(1, 1, HI, 1, 0, 0, 1, "R9 release leaving mid");
    step(1, 1, LO, 0, 1, 0, 0, "R2 exit after release");
    // R3: enable low
    step(1, 0, HI, 0, 0, 0, 1, "R3 enable low");
    step(1, 0, LO, 0, 0, 0, 1, "R3 enable low pwm low");
    step(1, 1, LO, 0, 0, 0, 1, "R2 no transition no exit");
    step(1, 1, HI, 0, 0, 0, 1, "R6 high in hiz");
    step(1, 1, LO, 0, 1, 0, 0, "R2 exit on new low");
    // R10: supply drop clears latch
    step(1, 0, LO, 0, 0, 0, 1, "R3 disable again");
    step(1, 0, LO, 1, 0, 1, 0, "R8 trip while disabled");
    step(0, 0, LO, 1, 0, 0, 1, "R10 supply lost");
    step(1, 0, MD, 0, 0, 0, 1, "R10 latch clear after return");
    step(1, 0, MD, 0, 0, 0, 1, "R10 still clear");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule